// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps program order for a speculative out-of-order core. Issue logic allocates one entry per cycle. Each entry records the operation class, the destination kind and the destination index or address. The index of the allocated entry comes back as the rename tag, and reservation stations and the register status table use that tag, not a functional-unit number, to name a pending producer.

Results broadcast on the writeback port are held in the entry until it reaches the head. Only then are they released as a register-file write or a memory store request. The oldest entry retires once its result has been present for at least one cycle. This keeps exceptions precise. A faulting entry retires as an exception indication and empties the buffer, so neither it nor anything younger touches architectural state. A branch found mispredicted at retirement empties the buffer the same way, and so does the external flush input.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0 and every commit output is 0.
- R2: Accepted allocations receive tags in sequence, starting at 0 and wrapping from DEPTH-1 back to 0. `alloc_tag` always shows the tag the next accepted allocation will get.
- R3: With DEPTH entries occupied, `alloc_ready` is 0 and a request is refused, even in a cycle in which the head retires.
- R4: Only the head entry retires. A younger entry that already has its result waits until every older entry has retired.
- R5: A writeback to the head entry does not cause retirement in the cycle it is presented. Retirement (`cm_valid`=1) appears in the next cycle.
- R6: A normal retirement acts on the destination kind: 2 gives `cm_reg_we` with `cm_dest` and `cm_data`, 1 gives `cm_mem_we` with address `cm_dest` and `cm_data`, and 0 writes nothing. At most one of `cm_reg_we`, `cm_mem_we`, `cm_fault` and `cm_flush` is high in a cycle.
- R7: A head entry written back with the fault flag retires as `cm_fault`=1 with no register or memory write. All entries are then discarded and the next tag is 0.
- R8: A head entry of operation class 3 (branch) written back with the mispredict flag retires as `cm_flush`=1. All younger entries are discarded and the next tag is 0. The mispredict flag has no effect on other classes.
- R9: `flush_in` suppresses retirement in its cycle and empties the buffer, so the next tag is 0. Later writebacks to discarded tags have no effect.
- R10: Allocation is refused (`alloc_ready`=0) in any cycle with `cm_fault`, `cm_flush` or `flush_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_in | input | 1 | Discard all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 2 | Operation class, 3 = branch |
| alloc_dkind | input | 2 | Destination kind: 0 none, 1 memory, 2 register |
| alloc_dest | input | DEST_W | Register index or memory address |
| alloc_ready | output | 1 | Request will be accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the accepted request |
| wb_valid | input | 1 | Result broadcast |
| wb_tag | input | TAG_W | Entry being completed |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Result raised an exception |
| wb_mispred | input | 1 | Branch resolved as mispredicted |
| cm_valid | output | 1 | Head entry retires this cycle |
| cm_tag | output | TAG_W | Tag of the retiring entry |
| cm_reg_we | output | 1 | Register-file write |
| cm_mem_we | output | 1 | Store request to memory |
| cm_dest | output | DEST_W | Register index or store address |
| cm_data | output | DATA_W | Value to write |
| cm_fault | output | 1 | Precise exception at this entry |
| cm_flush | output | 1 | Mispredicted branch retired, younger work discarded |

## Verification
The retirement outputs and `alloc_ready` are combinational on registered state. Each stimulus therefore shows its effect in the cycle after the clock edge that captures it. A writeback, allocation or flush presented at edge t is visible in the outputs between edges t and t+1. The bench drives inputs on the falling edge and samples the outputs 1 ns later, against a reference model that advances once per rising edge. Every comparison uses state from edges already taken, plus the inputs of the current cycle where a requirement makes an output depend on them (R10).

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_in,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_op,
  input  logic [1:0]        alloc_dkind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_fault,
  input  logic              wb_mispred,
  output logic              cm_valid,
  output logic [TAG_W-1:0]  cm_tag,
  output logic              cm_reg_we,
  output logic              cm_mem_we,
  output logic [DEST_W-1:0] cm_dest,
  output logic [DATA_W-1:0] cm_data,
  output logic              cm_fault,
  output logic              cm_flush
);
  localparam logic [1:0] OP_BRANCH = 2'd3;
  localparam logic [1:0] DK_MEM    = 2'd1;
  localparam logic [1:0] DK_REG    = 2'd2;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DEPTH-1:0]  vld, done, flt, mis;
  logic [1:0]        op_q   [DEPTH];
  logic [1:0]        dk_q   [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [TAG_W-1:0] step_ptr(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic retire_ok, do_alloc, clear_all;

  assign cm_valid  = vld[head] & done[head] & ~flush_in;
  assign cm_tag    = head;
  assign cm_dest   = dest_q[head];
  assign cm_data   = val_q[head];
  assign cm_fault  = cm_valid & flt[head];
  assign cm_flush  = cm_valid & ~flt[head] & mis[head] & (op_q[head] == OP_BRANCH);
  assign retire_ok = cm_valid & ~cm_fault & ~cm_flush;
  assign cm_reg_we = retire_ok & (dk_q[head] == DK_REG);
  assign cm_mem_we = retire_ok & (dk_q[head] == DK_MEM);
  assign clear_all = flush_in | cm_fault | cm_flush;

  assign alloc_ready = (cnt != FULL) & ~clear_all;
  assign alloc_tag   = tail;
  assign do_alloc    = alloc_valid & alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      vld  <= '0;
      done <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (wb_valid && vld[wb_tag]) begin
        done[wb_tag]  <= 1'b1;
        flt[wb_tag]   <= wb_fault;
        mis[wb_tag]   <= wb_mispred;
        val_q[wb_tag] <= wb_value;
      end
      if (retire_ok) begin
        vld[head] <= 1'b0;
        head      <= step_ptr(head);
      end
      if (do_alloc) begin
        vld[tail]    <= 1'b1;
        done[tail]   <= 1'b0;
        flt[tail]    <= 1'b0;
        mis[tail]    <= 1'b0;
        op_q[tail]   <= alloc_op;
        dk_q[tail]   <= alloc_dkind;
        dest_q[tail] <= alloc_dest;
        tail         <= step_ptr(tail);
      end
      case ({do_alloc, retire_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL) |-> !alloc_ready);

  // R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, cm_fault, cm_flush}));

  // R7 R8
  squash_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_fault || cm_flush) |=> (!cm_valid && alloc_tag == '0));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_in |=> (!cm_valid && alloc_tag == '0));

  // R4
  head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_tag == head && cnt != '0));
endmodule

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
  localparam int D = 8;
  localparam int DW = 32;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0;
  logic flush_in = 0, alloc_valid = 0, wb_valid = 0, wb_fault = 0, wb_mispred = 0;
  logic [1:0] alloc_op = 0, alloc_dkind = 0;
  logic [SW-1:0] alloc_dest = 0;
  logic [2:0] wb_tag = 0;
  logic [DW-1:0] wb_value = 0;
  logic alloc_ready, cm_valid, cm_reg_we, cm_mem_we, cm_fault, cm_flush;
  logic [2:0] alloc_tag, cm_tag;
  logic [SW-1:0] cm_dest;
  logic [DW-1:0] cm_data;

  reorder_buf #(.DEPTH(D), .DATA_W(DW), .DEST_W(SW)) uut (
    .clk, .rst_n, .flush_in, .alloc_valid, .alloc_op, .alloc_dkind, .alloc_dest,
    .alloc_ready, .alloc_tag, .wb_valid, .wb_tag, .wb_value, .wb_fault, .wb_mispred,
    .cm_valid, .cm_tag, .cm_reg_we, .cm_mem_we, .cm_dest, .cm_data, .cm_fault, .cm_flush);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit ended = 0;

  bit m_v[D], m_d[D], m_f[D], m_m[D];
  bit [1:0] m_op[D], m_dk[D];
  bit [SW-1:0] m_dst[D];
  bit [DW-1:0] m_val[D];
  int mh = 0, mt = 0, mc = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(int p);
    return (p == D - 1) ? 0 : p + 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < D; i++) begin m_v[i] = 0; m_d[i] = 0; end
    mh = 0; mt = 0; mc = 0;
  endtask

  task automatic step(bit av, bit [1:0] aop, bit [1:0] adk, bit [SW-1:0] adst,
                      bit wv, int wt, bit [DW-1:0] wval, bit wf, bit wm, bit fl);
    bit e_cv, e_fault, e_fl, e_norm, e_rdy;
    @(negedge clk);
    alloc_valid = av; alloc_op = aop; alloc_dkind = adk; alloc_dest = adst;
    wb_valid = wv; wb_tag = wt[2:0]; wb_value = wval; wb_fault = wf; wb_mispred = wm;
    flush_in = fl;
    #1;
    e_cv    = m_v[mh] && m_d[mh] && !fl;
    e_fault = e_cv && m_f[mh];
    e_fl    = e_cv && !m_f[mh] && m_m[mh] && m_op[mh] == 2'd3;
    e_norm  = e_cv && !e_fault && !e_fl;
    e_rdy   = (mc != D) && !e_fault && !e_fl && !fl;
    chk("R3 R10 alloc_ready", alloc_ready, e_rdy);
    chk("R2 alloc_tag", alloc_tag, mt);
    chk("R4 cm_valid", cm_valid, e_cv);
    chk("R7 cm_fault", cm_fault, e_fault);
    chk("R8 cm_flush", cm_flush, e_fl);
    chk("R6 cm_reg_we", cm_reg_we, e_norm && m_dk[mh] == 2);
    chk("R6 cm_mem_we", cm_mem_we, e_norm && m_dk[mh] == 1);
    if (e_cv) chk("R4 cm_tag", cm_tag, mh);
    if (e_norm && m_dk[mh] != 0) begin
      chk("R6 cm_dest", cm_dest, m_dst[mh]);
      chk("R6 cm_data", cm_data, m_val[mh]);
    end
    if (fl || e_fault || e_fl) model_clear();
    else begin
      if (wv && m_v[wt]) begin
        m_d[wt] = 1; m_f[wt] = wf; m_m[wt] = wm; m_val[wt] = wval;
      end
      if (e_norm) begin m_v[mh] = 0; mh = nxt(mh); mc--; end
      if (av && e_rdy) begin
        m_v[mt] = 1; m_d[mt] = 0; m_f[mt] = 0; m_m[mt] = 0;
        m_op[mt] = aop; m_dk[mt] = adk; m_dst[mt] = adst;
        mt = nxt(mt); mc++;
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_tag", alloc_tag, 0);
    chk("R1 commit outputs", {cm_valid, cm_reg_we, cm_mem_we, cm_fault, cm_flush}, 0);

    // R2 R3 fill the buffer, then try once more while full
    for (int i = 0; i < D; i++) step(1, 0, 2, SW'(i + 3), 0, 0, 0, 0, 0, 0);
    step(1, 0, 2, 16'h77, 0, 0, 0, 0, 0, 0);
    // R4 younger entry completes first
    step(0, 0, 0, 0, 1, 1, 32'hB1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 32'hA0, 0, 0, 0);
    // R5 no retirement in the writeback cycle itself
    chk("R5 same cycle as writeback", cm_valid, 0);
    // R3 head retires while full: allocation still refused
    step(1, 0, 2, 16'h55, 0, 0, 0, 0, 0, 0);
    chk("R5 one cycle after writeback", cm_valid, 1);
    idle();
    // R7 fault on entry 2 discards everything
    step(0, 0, 0, 0, 1, 2, 32'hC2, 1, 0, 0);
    step(1, 0, 2, 16'h9, 0, 0, 0, 0, 0, 0);
    chk("R7 tag restarts", alloc_tag, 0);

    // R8 mispredicted branch and non-branch with mispredict flag
    step(1, 0, 1, 16'h100, 0, 0, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 2, 16'h4, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 32'h1234, 0, 1, 0);
    step(0, 0, 0, 0, 1, 2, 32'h5, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 32'h0, 0, 1, 0);
    idle(); idle();
    chk("R8 tag restarts", alloc_tag, 0);

    // R9 flush, then writeback to a discarded tag
    step(1, 0, 2, 16'h1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 2, 16'h2, 1, 0, 32'h11, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 1, 32'h22, 0, 0, 0);
    chk("R9 tag after flush", alloc_tag, 0);
    idle();
    chk("R9 stale writeback ignored", cm_valid, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit av, wv, wf, wm, fl;
      int wt, start;
      av = ($urandom % 3) != 0;
      wv = 0; wt = 0;
      start = $urandom % D;
      for (int k = 0; k < D; k++) begin
        int j;
        j = (start + k) % D;
        if (!wv && m_v[j] && !m_d[j]) begin wv = ($urandom % 2) == 1; wt = j; end
      end
      if (!wv && ($urandom % 16) == 0) begin wv = 1; wt = $urandom % D; end
      wf = ($urandom % 20) == 0;
      wm = ($urandom % 6) == 0;
      fl = ($urandom % 80) == 0;
      step(av, 2'($urandom), 2'($urandom % 3), SW'($urandom), wv, wt, $urandom, wf, wm, fl);
    end

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule